// File: doc/BRIEF.md
# Spare-Row Repair Logger and Address Remapper

This block sits beside an embedded memory that carries a few spare rows. While a self-test engine runs its first pass, the block collects every row address that the engine reports as failing, drops repeats, and gives each new faulty row one spare. If more distinct rows fail than there are spares, it raises a sticky unrepairable flag.

Outside the logging pass, the block turns a functional row address into a physical row select. A row that matches a repair entry goes to the spare bank at that entry's index. Any other row passes through unchanged. A second self-test pass, started without clearing the log, runs through this redirect. Its outcome confirms or rejects the repair. At power-up the map can be loaded from stored fuse values, so it does not have to be learned again.

Top module: `row_spare_repair`

## Requirements
- R1: After reset, all repair entries are invalid. The unrepairable, repair_ok, repair_bad, logging and verifying outputs are 0, and phys_sel equals {1'b0, func_row}.
- R2: During logging, a fail strobe whose row matches no valid entry writes that row into the lowest-numbered invalid entry and marks it valid. The map_tags field of entry i is bits [8*i+7 : 8*i]. A valid entry i reads as map_valid[i]=1.
- R3: During logging, a fail strobe whose row matches a valid entry changes no entry.
- R4: A distinct failing row that arrives when all 4 entries are valid sets unrepairable and allocates nothing. The flag stays set until a test start with clear_log, or until a fuse load.
- R5: While logging is 1, phys_sel equals {1'b0, func_row}, even for a row held in a valid entry.
- R6: When logging is 0 and func_row matches valid entries, phys_sel is {1'b1, 6'b0, i}, where i is the lowest matching entry index. When no entry matches, phys_sel is {1'b0, func_row}.
- R7: test_start with clear_log=1 invalidates every entry, clears unrepairable and enters logging. test_start with clear_log=0 keeps the entries and enters verifying. Both forms clear repair_ok and repair_bad. A fail strobe in the same cycle as test_start is ignored.
- R8: During verifying, fail strobes do not change the map. At test_done the block sets repair_ok=1 if no fail strobe occurred in that pass (the test_done cycle included) and unrepairable is 0. Otherwise it sets repair_bad=1. The two flags are never 1 together.
- R9: In the idle state, fuse_load copies fuse_valid and fuse_tags into the map, using the field layout of R2, and clears unrepairable.
- R10: A fail strobe in the same cycle as test_done still takes effect: it is logged in the logging pass and counted as a failure in the verifying pass. In both cases the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_start | input | 1 | Self-test pass begins |
| clear_log | input | 1 | With test_start: empty the map and log (1), or verify (0) |
| test_done | input | 1 | Self-test pass ends |
| fail_vld | input | 1 | Fail strobe from the self-test engine |
| fail_row | input | 8 | Failing row address |
| fuse_load | input | 1 | Load the map from fuse values (idle only) |
| fuse_valid | input | 4 | Stored entry valid bits |
| fuse_tags | input | 32 | Stored entry row tags, 8 bits per entry |
| func_row | input | 8 | Functional row address |
| phys_sel | output | 9 | MSB selects the spare bank; low bits hold the row or the spare index |
| logging | output | 1 | Logging pass active |
| verifying | output | 1 | Verifying pass active |
| unrepairable | output | 1 | More distinct faulty rows than spares |
| repair_ok | output | 1 | Verifying pass ended clean |
| repair_bad | output | 1 | Verifying pass failed or the map had overflowed |
| map_valid | output | 4 | Entry valid bits |
| map_tags | output | 32 | Entry row tags |

## Verification
The tightest collision is a fail strobe in the same cycle as test_done, which closes a pass. The bench raises both strobes in one cycle, once during a logging pass and once during a verifying pass. The first must still allocate an entry and the second must still give repair_bad. A fail strobe arriving together with test_start is driven as well, and the bench confirms that the map is left untouched.

// File: rtl/row_spare_repair.sv
module row_spare_repair #(
  parameter int ROW_W  = 8,
  parameter int SPARES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    test_start,
  input  logic                    clear_log,
  input  logic                    test_done,
  input  logic                    fail_vld,
  input  logic [ROW_W-1:0]        fail_row,
  input  logic                    fuse_load,
  input  logic [SPARES-1:0]       fuse_valid,
  input  logic [SPARES*ROW_W-1:0] fuse_tags,
  input  logic [ROW_W-1:0]        func_row,
  output logic [ROW_W:0]          phys_sel,
  output logic                    logging,
  output logic                    verifying,
  output logic                    unrepairable,
  output logic                    repair_ok,
  output logic                    repair_bad,
  output logic [SPARES-1:0]       map_valid,
  output logic [SPARES*ROW_W-1:0] map_tags
);
  localparam int IDX_W = (SPARES > 1) ? $clog2(SPARES) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOG, ST_VERIFY} st_t;
  st_t st;

  logic [ROW_W-1:0]  tag_q [SPARES];
  logic [SPARES-1:0] vld_q;
  logic [SPARES-1:0] fail_match, func_match;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  logic              has_free, vfail_q, spare_hit;

  for (genvar g = 0; g < SPARES; g++) begin : g_ent
    assign fail_match[g]             = vld_q[g] && (tag_q[g] == fail_row);
    assign func_match[g]             = vld_q[g] && (tag_q[g] == func_row);
    assign map_tags[g*ROW_W +: ROW_W] = tag_q[g];
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    has_free = 1'b0;
    for (int i = SPARES - 1; i >= 0; i--) begin
      if (func_match[i]) hit_idx = IDX_W'(i);
      if (!vld_q[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign logging   = (st == ST_LOG);
  assign verifying = (st == ST_VERIFY);
  assign map_valid = vld_q;
  assign spare_hit = !logging && (|func_match);
  assign phys_sel  = spare_hit ? {1'b1, ROW_W'(hit_idx)} : {1'b0, func_row};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      vld_q        <= '0;
      for (int i = 0; i < SPARES; i++) tag_q[i] <= '0;
      unrepairable <= 1'b0;
      repair_ok    <= 1'b0;
      repair_bad   <= 1'b0;
      vfail_q      <= 1'b0;
    end else if (test_start) begin
      st         <= clear_log ? ST_LOG : ST_VERIFY;
      repair_ok  <= 1'b0;
      repair_bad <= 1'b0;
      vfail_q    <= 1'b0;
      if (clear_log) begin
        vld_q        <= '0;
        unrepairable <= 1'b0;
      end
    end else begin
      case (st)
        ST_LOG: begin
          if (fail_vld && !(|fail_match)) begin
            if (has_free && !unrepairable) begin
              vld_q[free_idx] <= 1'b1;
              tag_q[free_idx] <= fail_row;
            end else begin
              unrepairable <= 1'b1;
            end
          end
          if (test_done) st <= ST_IDLE;
        end
        ST_VERIFY: begin
          if (test_done) begin
            st <= ST_IDLE;
            if (vfail_q || fail_vld || unrepairable) repair_bad <= 1'b1;
            else                                     repair_ok  <= 1'b1;
          end else if (fail_vld) begin
            vfail_q <= 1'b1;
          end
        end
        default: begin
          if (fuse_load) begin
            vld_q        <= fuse_valid;
            unrepairable <= 1'b0;
            for (int i = 0; i < SPARES; i++) tag_q[i] <= fuse_tags[i*ROW_W +: ROW_W];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/row_spare_repair_chk.sv
module row_spare_repair_chk #(
  parameter int ROW_W  = 8,
  parameter int SPARES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    test_start,
  input logic                    clear_log,
  input logic                    fuse_load,
  input logic [ROW_W:0]          phys_sel,
  input logic                    logging,
  input logic                    unrepairable,
  input logic                    repair_ok,
  input logic                    repair_bad,
  input logic [SPARES-1:0]       map_valid
);
  a_r4_sticky_unrep: assert property (@(posedge clk) disable iff (!rst_n)
    unrepairable && !test_start && !fuse_load |=> unrepairable);

  a_r5_bypass_when_logging: assert property (@(posedge clk) disable iff (!rst_n)
    logging |-> !phys_sel[ROW_W]);

  a_r2_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    logging && !test_start |=> $countones(map_valid) <= $countones($past(map_valid)) + 1);

  a_r3_entries_kept: assert property (@(posedge clk) disable iff (!rst_n)
    logging && !test_start |=> (map_valid & $past(map_valid)) == $past(map_valid));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    test_start && clear_log |=> map_valid == '0);

  a_r8_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(repair_ok && repair_bad));

  a_r8_ok_needs_repairable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repair_ok) |-> !unrepairable);
endmodule

bind row_spare_repair row_spare_repair_chk #(.ROW_W(ROW_W), .SPARES(SPARES)) chk_i (.*);

// File: tb/row_spare_repair_tb_top.sv
`timescale 1ns/1ps
module row_spare_repair_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic test_start = 0, clear_log = 0, test_done = 0, fail_vld = 0, fuse_load = 0;
  logic [7:0]  fail_row = '0, func_row = '0;
  logic [3:0]  fuse_valid = '0;
  logic [31:0] fuse_tags = '0;
  logic [8:0]  phys_sel;
  logic logging, verifying, unrepairable, repair_ok, repair_bad;
  logic [3:0]  map_valid;
  logic [31:0] map_tags;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  row_spare_repair dut_i (.*);

  // {fail row, expected map_valid, expected unrepairable}
  localparam logic [12:0] VEC [8] = '{
    {8'h10, 4'b0001, 1'b0}, {8'h10, 4'b0001, 1'b0},
    {8'h20, 4'b0011, 1'b0}, {8'hFF, 4'b0111, 1'b0},
    {8'h20, 4'b0111, 1'b0}, {8'h00, 4'b1111, 1'b0},
    {8'h33, 4'b1111, 1'b1}, {8'h10, 4'b1111, 1'b1}};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic start(bit clr);
    test_start = 1; clear_log = clr; cyc(); test_start = 0; clear_log = 0;
  endtask

  task automatic fail(logic [7:0] r, bit done);
    fail_vld = 1; fail_row = r; test_done = done; cyc(); fail_vld = 0; test_done = 0;
  endtask

  initial begin
    #1; func_row = 8'h10;
    repeat (3) cyc();
    chk("R1 valid", map_valid, 0);
    chk("R1 flags", {unrepairable, repair_ok, repair_bad, logging, verifying}, 0);
    chk("R1 phys", phys_sel, {1'b0, 8'h10});
    rst_n = 1; cyc();

    start(1);
    chk("R7 logging", logging, 1);
    foreach (VEC[i]) begin
      fail(VEC[i][12:5], 0);
      chk($sformatf("R2/R3/R4 valid step %0d", i), map_valid, VEC[i][4:1]);
      chk($sformatf("R4 unrep step %0d", i), unrepairable, VEC[i][0]);
    end
    chk("R2 tags", map_tags, 32'h00FF2010);
    func_row = 8'h20; #1;
    chk("R5 bypass", phys_sel, {1'b0, 8'h20});
    test_done = 1; cyc(); test_done = 0;
    chk("R6 remap after log", phys_sel, {1'b1, 8'd1});
    start(0);
    chk("R7 keep entries", map_valid, 4'b1111);
    test_done = 1; cyc(); test_done = 0;
    chk("R8 overflow rejects", {repair_ok, repair_bad}, 2'b01);
    chk("R4 still unrep", unrepairable, 1);

    fuse_valid = 4'b0110; fuse_tags = 32'h00444400; fuse_load = 1; cyc(); fuse_load = 0;
    chk("R9 fuse valid", map_valid, 4'b0110);
    chk("R9 fuse clears unrep", unrepairable, 0);
    func_row = 8'h44; #1;
    chk("R6 lowest match", phys_sel, {1'b1, 8'd1});
    func_row = 8'h45; #1;
    chk("R6 no match", phys_sel, {1'b0, 8'h45});

    start(1);
    chk("R7 clear", map_valid, 0);
    test_start = 1; clear_log = 1; fail_vld = 1; fail_row = 8'h77; cyc();
    test_start = 0; clear_log = 0; fail_vld = 0;
    chk("R7 fail with start ignored", map_valid, 0);
    fail(8'h05, 1);
    chk("R10 logged at done", map_valid, 4'b0001);
    chk("R10 idle", logging, 0);
    func_row = 8'h05; #1;
    chk("R6 remap", phys_sel, {1'b1, 8'd0});
    start(0);
    chk("R8 verifying", verifying, 1);
    fail(8'h09, 0);
    chk("R8 no log in verify", map_valid, 4'b0001);
    test_done = 1; cyc(); test_done = 0;
    chk("R8 fail rejects", {repair_ok, repair_bad}, 2'b01);
    start(0);
    chk("R7 results cleared", {repair_ok, repair_bad}, 0);
    test_done = 1; cyc(); test_done = 0;
    chk("R8 clean confirms", {repair_ok, repair_bad}, 2'b10);
    start(0);
    fail(8'h05, 1);
    chk("R10 fail at done rejects", {repair_ok, repair_bad}, 2'b01);
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin repeat (5000) @(posedge clk); n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule